// File: doc/BRIEF.md
# Timed-Access Protected Watchdog

This block is a watchdog counter that advances once per machine-cycle tick while it is enabled. When software does not restart it within a fixed number of ticks, it raises a single-clock expiry pulse. The reset controller takes this pulse as an internal reset request. The enable bit and the restart bit cannot be changed by an ordinary register write. Software must first unlock them by writing a two-value key to a dedicated key register on back-to-back clocks. This opens a short window, and only one protected write is accepted inside it.

The block sits on a simple write-only register port made of a write strobe, an address and a byte of data. A power-on reset (`rst_n`) disables the watchdog. The synchronous system-reset input stands for every other reset type. It returns the count to zero and closes any open window, but it leaves the enable bit as it was.

Top module: `wdog_guarded`

## Requirements
- R1: While `rst_n` is low and on its release, `wd_enabled`, `ta_open` and `expire_pulse` are all 0.
- R2: A write of 0xAA to the key register (address 0xE), followed on the very next clock by a write of 0x55 to the same address, opens the window. `ta_open` reads 1 after the second write's clock edge.
- R3: The window accepts a protected write on any of the `WIN_CLKS` (default 4) clock edges that follow the second key write. If no protected write arrives, `ta_open` drops after the last of those edges.
- R4: A write to the control register (0x7) or the priority register (0x8) made while `ta_open` is 0 is ignored. An accepted protected write closes the window on the same edge.
- R5: A protected write to the control register copies data bit 0 into the enable bit, which appears on `wd_enabled`.
- R6: Any value other than the expected key written to the key register closes the window or abandons the sequence. A clock with no key write between 0xAA and 0x55 also abandons the sequence.
- R7: The count advances only on clock edges where `tick` is 1 and the watchdog is enabled. `expire_pulse` is high for exactly one clock after the `TIMEOUT`-th counted tick (default 122,880).
- R8: After an expiry the count starts again from zero, so the next pulse comes after another `TIMEOUT` ticks.
- R9: A protected write with bit 7 set to the priority register restarts the count from zero. A protected write with bit 7 clear, or an unprotected write, leaves the count untouched.
- R10: `sys_rst` returns the count to zero and closes the window, while `wd_enabled` keeps its value.
- R11: While the watchdog is disabled the count is held at zero, so re-enabling it starts a full `TIMEOUT` period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset; disables the watchdog |
| sys_rst | input | 1 | Synchronous reset of any other type; clears count and window |
| tick | input | 1 | Machine-cycle tick, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register write address |
| wr_data | input | 8 | Register write data |
| wd_enabled | output | 1 | Current enable bit |
| expire_pulse | output | 1 | One-clock timeout pulse toward the reset controller |
| ta_open | output | 1 | High while the timed-access window is open |

## Verification
The bench builds two copies of the block on shared stimulus. One copy keeps the default 122,880-tick timeout, so the exact expiry point is checked at full size once. The other copy is built with `TIMEOUT` set to 50, which makes the behaviour around expiry affordable: restarts, ignored restarts, the system reset, tick gating and disabling can all be checked against a precise tick count many times over. Both copies keep the default window of 4 clocks, so the first and last window slots and the window timeout are reached directly by the table of register writes.

// File: rtl/wdog_guarded_pkg.sv
package wdog_guarded_pkg;

  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_HALF   = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_state_e;

  // True when the counter value is the last one before expiry.
  function automatic logic at_limit(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

  // Number of window clocks left after the current one.
  function automatic int unsigned window_load(input int unsigned slots);
    return (slots > 0) ? slots - 1 : 0;
  endfunction

endpackage

// File: rtl/wdog_ta_gate.sv
module wdog_ta_gate
  import wdog_guarded_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int WIN_CLKS = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'hE,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h7,
  parameter logic [ADDR_W-1:0] PRIO_ADDR = 4'h8,
  parameter logic [7:0] KEY_FIRST  = 8'hAA,
  parameter logic [7:0] KEY_SECOND = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              gate_open,
  output logic              prot_accept,
  output logic              key_bad
);

  localparam int WIN_W = (WIN_CLKS > 1) ? $clog2(WIN_CLKS) : 1;
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(window_load(WIN_CLKS));

  gate_state_e      state_q, state_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             key_wr, prot_target;

  assign key_wr      = wr_en && (wr_addr == KEY_ADDR);
  assign prot_target = wr_en && ((wr_addr == CTRL_ADDR) || (wr_addr == PRIO_ADDR));
  assign gate_open   = (state_q == GATE_OPEN);
  assign prot_accept = gate_open && prot_target;
  assign key_bad     = key_wr &&
                       !((state_q == GATE_LOCKED) && (wr_data == KEY_FIRST)) &&
                       !((state_q == GATE_HALF)   && (wr_data == KEY_SECOND)) &&
                       !((state_q == GATE_OPEN)   && (wr_data == KEY_FIRST));

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    if (sys_rst) begin
      state_d = GATE_LOCKED;
      win_d   = '0;
    end else begin
      unique case (state_q)
        GATE_LOCKED: begin
          if (key_wr && (wr_data == KEY_FIRST)) state_d = GATE_HALF;
        end
        GATE_HALF: begin
          if (key_wr && (wr_data == KEY_SECOND)) begin
            state_d = GATE_OPEN;
            win_d   = WIN_LOAD;
          end else begin
            state_d = GATE_LOCKED;
          end
        end
        GATE_OPEN: begin
          if (key_wr) begin
            state_d = (wr_data == KEY_FIRST) ? GATE_HALF : GATE_LOCKED;
          end else if (prot_target) begin
            state_d = GATE_LOCKED;
          end else if (win_q == '0) begin
            state_d = GATE_LOCKED;
          end else begin
            win_d = win_q - 1'b1;
          end
        end
        default: state_d = GATE_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_LOCKED;
      win_q   <= '0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
    end
  end

endmodule

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs #(
  parameter int ADDR_W  = 4,
  parameter int EN_BIT  = 0,
  parameter int RST_BIT = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h7,
  parameter logic [ADDR_W-1:0] PRIO_ADDR = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_accept,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              enable,
  output logic              restart
);

  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (prot_accept && (wr_addr == CTRL_ADDR)) begin
      en_q <= wr_data[EN_BIT];
    end
  end

  assign enable  = en_q;
  assign restart = prot_accept && (wr_addr == PRIO_ADDR) && wr_data[RST_BIT];

endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_guarded_pkg::*;
#(
  parameter int TIMEOUT = 122880,
  parameter int CNT_W   = $clog2(TIMEOUT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst,
  input  logic             enable,
  input  logic             restart,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;
  logic             last;

  assign last = at_limit(int'(cnt_q), TIMEOUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (sys_rst || restart || !enable) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (last) begin
          cnt_q   <= '0;
          pulse_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign count  = cnt_q;
  assign expire = pulse_q;

endmodule

// File: rtl/wdog_guarded.sv
module wdog_guarded #(
  parameter int TIMEOUT  = 122880,
  parameter int WIN_CLKS = 4,
  parameter int ADDR_W   = 4,
  parameter int EN_BIT   = 0,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'hE,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h7,
  parameter logic [ADDR_W-1:0] PRIO_ADDR = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              wd_enabled,
  output logic              expire_pulse,
  output logic              ta_open
);

  localparam int CNT_W = $clog2(TIMEOUT);

  logic             prot_accept;
  logic             key_bad;
  logic             restart_evt;
  logic [CNT_W-1:0] cnt_w;

  wdog_ta_gate #(
    .ADDR_W(ADDR_W), .WIN_CLKS(WIN_CLKS),
    .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR), .PRIO_ADDR(PRIO_ADDR)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gate_open(ta_open), .prot_accept(prot_accept), .key_bad(key_bad)
  );

  wdog_ctrl_regs #(
    .ADDR_W(ADDR_W), .EN_BIT(EN_BIT), .RST_BIT(7),
    .CTRL_ADDR(CTRL_ADDR), .PRIO_ADDR(PRIO_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .prot_accept(prot_accept),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .enable(wd_enabled), .restart(restart_evt)
  );

  wdog_count #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
    .enable(wd_enabled), .restart(restart_evt), .tick(tick),
    .count(cnt_w), .expire(expire_pulse)
  );

endmodule

// File: rtl/wdog_guarded_chk.sv
module wdog_guarded_chk #(
  parameter int TIMEOUT = 122880,
  parameter int CNT_W   = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_rst,
  input logic             tick,
  input logic             wd_enabled,
  input logic             expire_pulse,
  input logic             ta_open,
  input logic             prot_accept,
  input logic             key_bad,
  input logic             restart_evt,
  input logic [CNT_W-1:0] cnt
);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |=> !expire_pulse);

  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |-> ($past(tick) && $past(wd_enabled)));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(TIMEOUT));

  assert_no_tick_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && wd_enabled && !restart_evt && !sys_rst) |=> $stable(cnt));

  assert_en_needs_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wd_enabled) |-> $past(ta_open));

  assert_accept_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prot_accept |=> !ta_open);

  assert_bad_key_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_bad |=> !ta_open);

  assert_restart_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (cnt == '0));

  assert_sysrst_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> ((cnt == '0) && !ta_open));

  assert_disabled_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wd_enabled) && !wd_enabled) |-> (cnt == '0));

endmodule

bind wdog_guarded wdog_guarded_chk #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .tick(tick),
  .wd_enabled(wd_enabled), .expire_pulse(expire_pulse), .ta_open(ta_open),
  .prot_accept(prot_accept), .key_bad(key_bad), .restart_evt(restart_evt),
  .cnt(cnt_w)
);

// File: tb/wdog_guarded_test.sv
module wdog_guarded_test;

  localparam int SHORT_TO = 50;
  localparam int LONG_TO  = 122880;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_rst = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic en_l, exp_l, open_l, en_s, exp_s, open_s;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  wdog_guarded uut (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wd_enabled(en_l), .expire_pulse(exp_l), .ta_open(open_l)
  );

  wdog_guarded #(.TIMEOUT(SHORT_TO)) uut_short (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wd_enabled(en_s), .expire_pulse(exp_s), .ta_open(open_s)
  );

  typedef struct packed {
    logic       we;
    logic [3:0] a;
    logic [7:0] d;
    logic       open;
    logic       en;
  } vec_t;

  // Addresses: key 0xE, control 0x7 (enable = bit 0), priority 0x8.
  localparam vec_t VECS [25] = '{
    '{1'b1, 4'h7, 8'h01, 1'b0, 1'b0},  // R4 unprotected enable ignored
    '{1'b1, 4'hE, 8'hAA, 1'b0, 1'b0},
    '{1'b1, 4'hE, 8'h55, 1'b1, 1'b0},  // R2 window opens
    '{1'b1, 4'h7, 8'h01, 1'b0, 1'b1},  // R5 enable set, R4 window closes
    '{1'b1, 4'h7, 8'h00, 1'b0, 1'b1},  // R4 outside window ignored
    '{1'b1, 4'hE, 8'hAA, 1'b0, 1'b1},
    '{1'b0, 4'h0, 8'h00, 1'b0, 1'b1},  // R6 gap in sequence
    '{1'b1, 4'hE, 8'h55, 1'b0, 1'b1},
    '{1'b1, 4'hE, 8'hAA, 1'b0, 1'b1},
    '{1'b1, 4'hE, 8'h55, 1'b1, 1'b1},
    '{1'b1, 4'hE, 8'h12, 1'b0, 1'b1},  // R6 wrong key closes
    '{1'b1, 4'h7, 8'h00, 1'b0, 1'b1},
    '{1'b1, 4'hE, 8'hAA, 1'b0, 1'b1},
    '{1'b1, 4'hE, 8'h55, 1'b1, 1'b1},
    '{1'b0, 4'h0, 8'h00, 1'b1, 1'b1},  // R3 window slots
    '{1'b0, 4'h0, 8'h00, 1'b1, 1'b1},
    '{1'b0, 4'h0, 8'h00, 1'b1, 1'b1},
    '{1'b1, 4'h7, 8'h00, 1'b0, 1'b0},  // R3 last slot accepted
    '{1'b1, 4'hE, 8'hAA, 1'b0, 1'b0},
    '{1'b1, 4'hE, 8'h55, 1'b1, 1'b0},
    '{1'b0, 4'h0, 8'h00, 1'b1, 1'b0},
    '{1'b0, 4'h0, 8'h00, 1'b1, 1'b0},
    '{1'b0, 4'h0, 8'h00, 1'b1, 1'b0},
    '{1'b0, 4'h0, 8'h00, 1'b0, 1'b0},  // R3 window times out
    '{1'b1, 4'h7, 8'h01, 1'b0, 1'b0}   // R3 late write ignored
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prot_wr(input logic [3:0] a, input logic [7:0] d);
    wr(4'hE, 8'hAA);
    wr(4'hE, 8'h55);
    wr(a, d);
  endtask

  task automatic run_ticks(input int n, output int ps, output int pl);
    ps = 0; pl = 0;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (exp_s) ps++;
      if (exp_l) pl++;
    end
    tick = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ps, pl;
    repeat (3) @(negedge clk);
    check(!en_l && !open_l && !exp_l && !en_s, "R1 reset outputs", int'({en_l, open_l, exp_l}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!en_l && !open_l && !exp_l, "R1 after release", int'({en_l, open_l, exp_l}), 0);

    for (int i = 0; i < 25; i++) begin
      wr_en = VECS[i].we; wr_addr = VECS[i].a; wr_data = VECS[i].d;
      @(negedge clk);
      check(open_l == VECS[i].open && open_s == VECS[i].open,
            $sformatf("R2/R3/R6 window vec %0d", i), int'(open_l), int'(VECS[i].open));
      check(en_l == VECS[i].en && en_s == VECS[i].en,
            $sformatf("R4/R5 enable vec %0d", i), int'(en_l), int'(VECS[i].en));
    end
    wr_en = 1'b0;

    // Disabled: ticks do not count (R11).
    run_ticks(60, ps, pl);
    check(ps == 0, "R11 disabled no expiry", ps, 0);

    prot_wr(4'h7, 8'h01);
    check(en_s == 1'b1, "R5 enabled", int'(en_s), 1);
    run_ticks(SHORT_TO - 1, ps, pl);
    check(ps == 0, "R7 no pulse before timeout", ps, 0);
    run_ticks(1, ps, pl);
    check(ps == 1, "R7 pulse at timeout", ps, 1);
    @(negedge clk);
    check(exp_s == 1'b0, "R7 pulse one clock", int'(exp_s), 0);
    run_ticks(SHORT_TO - 1, ps, pl);
    check(ps == 0, "R8 count from zero after expiry", ps, 0);
    run_ticks(1, ps, pl);
    check(ps == 1, "R8 second expiry", ps, 1);

    // Restart via protected write (R9).
    run_ticks(30, ps, pl);
    prot_wr(4'h8, 8'h80);
    run_ticks(SHORT_TO - 1, ps, pl);
    check(ps == 0, "R9 restart clears count", ps, 0);
    run_ticks(1, ps, pl);
    check(ps == 1, "R9 full period after restart", ps, 1);

    // Bit 7 clear: no effect.
    run_ticks(30, ps, pl);
    prot_wr(4'h8, 8'h7F);
    run_ticks(20, ps, pl);
    check(ps == 1, "R9 zero write no restart", ps, 1);

    // Unprotected restart ignored.
    run_ticks(30, ps, pl);
    wr(4'h8, 8'h80);
    run_ticks(20, ps, pl);
    check(ps == 1, "R4 R9 unprotected restart ignored", ps, 1);

    // Tick gating: idle clocks do not count.
    run_ticks(30, ps, pl);
    repeat (200) @(negedge clk);
    run_ticks(19, ps, pl);
    check(ps == 0, "R7 idle clocks not counted", ps, 0);
    run_ticks(1, ps, pl);
    check(ps == 1, "R7 expiry after gated ticks", ps, 1);

    // System reset (R10).
    run_ticks(30, ps, pl);
    wr(4'hE, 8'hAA);
    wr(4'hE, 8'h55);
    sys_rst = 1'b1;
    @(negedge clk);
    sys_rst = 1'b0;
    check(open_s == 1'b0 && en_s == 1'b1, "R10 window closed enable kept",
          int'({open_s, en_s}), 1);
    run_ticks(SHORT_TO - 1, ps, pl);
    check(ps == 0, "R10 count cleared", ps, 0);
    run_ticks(1, ps, pl);
    check(ps == 1, "R10 full period after reset", ps, 1);

    // Disable then re-enable (R11).
    run_ticks(30, ps, pl);
    prot_wr(4'h7, 8'h00);
    check(en_s == 1'b0, "R5 disabled", int'(en_s), 0);
    run_ticks(100, ps, pl);
    check(ps == 0, "R11 no expiry while disabled", ps, 0);
    prot_wr(4'h7, 8'h01);
    run_ticks(SHORT_TO - 1, ps, pl);
    check(ps == 0, "R11 re-enable starts from zero", ps, 0);
    run_ticks(1, ps, pl);
    check(ps == 1, "R11 expiry after re-enable", ps, 1);

    // Default timeout (R7).
    sys_rst = 1'b1;
    @(negedge clk);
    sys_rst = 1'b0;
    run_ticks(LONG_TO - 1, ps, pl);
    check(pl == 0, "R7 default no pulse before 122880", pl, 0);
    run_ticks(1, ps, pl);
    check(pl == 1, "R7 default pulse at 122880", pl, 1);
    @(negedge clk);
    check(exp_l == 1'b0, "R7 default pulse one clock", int'(exp_l), 0);

    // Power-on reset disables (R1).
    rst_n = 1'b0;
    @(negedge clk);
    check(!en_l && !en_s && !open_l, "R1 power-on disables", int'({en_l, en_s}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule